// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small processor core that completes one instruction on every rising clock edge. It fetches a word from a read-only instruction port and decodes it. It reads two source registers and runs an ALU operation, then writes the result back on the same edge that moves the program counter. It handles eight instructions: add, sub, and, or, slt, load word, store word and branch-if-equal.

Instructions and data use separate ports. Both memories are outside the core. Each must return read data combinationally for the address shown in the same cycle. A data store takes effect on the rising edge while the write enable is high. The core cannot stall, so neither port has a valid/ready handshake and there is no back-pressure. Every cycle the core presents an address and expects an answer in that cycle. Addresses are byte addresses on word boundaries. The memories index words with address bits [31:2].

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter (`imem_addr`) is loaded with 0. Reset is synchronous and active high.
- R2: Unless a branch is taken, `imem_addr` grows by 4 on every rising edge.
- R3: Branch-if-equal has opcode [31:26]=000100 and compares the registers named in [25:21] and [20:16]. When they are equal, the next address is PC+4 plus the sign-extended [15:0] shifted left by 2. When they differ, the next address is PC+4.
- R4: A register instruction has opcode 000000 and shamt [10:6]=0. It writes to the register in [15:11] and selects its operation from [5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0).
- R5: Load word (opcode 100011) reads data memory at register[25:21] plus the sign-extended [15:0], with `dmem_re` high. It writes the read data into register [20:16]. Negative offsets work.
- R6: Store word (opcode 101011) drives register[20:16] on `dmem_wdata` to the address formed as in R5, with `dmem_we` high. It writes no register. `dmem_we` is low for every other instruction.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: When an instruction reads and writes the same register, it sees the value from before its own write.
- R9: A word with an unknown opcode, an unknown function code, or an R-type word with non-zero shamt changes neither registers nor memory. It only advances the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the PC |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |
| dmem_we | output | 1 | Store strobe, taken on the rising edge |
| dmem_re | output | 1 | Load strobe |

## Verification
The assertions assume that both memory ports answer combinationally and that every fetched word is fully defined. If either does not hold, the equality compare and the branch decision would see unknown values. The bench therefore fills the whole instruction memory before reset is released, with the program and a defined filler word. It also preloads every data word, so each load and each branch compare works on known values. Reset is held high from time zero, so the checks on PC steps only ever see a PC that came out of reset.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic    dst_is_rd;
    logic    reg_we;
    logic    use_imm;
    alu_op_e alu_op;
    logic    mem_we;
    logic    mem_re;
    logic    wb_from_mem;
    logic    is_branch;
  } ctrl_t;
endpackage

// File: rtl/core_ctrl.sv
module core_ctrl
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    unique case (opcode)
      OPC_REG: begin
        if (shamt == '0) begin
          ctl.dst_is_rd = 1'b1;
          ctl.reg_we    = 1'b1;
          unique case (funct)
            FN_ADD:  ctl.alu_op = ALU_ADD;
            FN_SUB:  ctl.alu_op = ALU_SUB;
            FN_AND:  ctl.alu_op = ALU_AND;
            FN_OR:   ctl.alu_op = ALU_OR;
            FN_SLT:  ctl.alu_op = ALU_SLT;
            default: ctl.reg_we = 1'b0;
          endcase
        end
      end
      OPC_LOAD: begin
        ctl.reg_we      = 1'b1;
        ctl.use_imm     = 1'b1;
        ctl.mem_re      = 1'b1;
        ctl.wb_from_mem = 1'b1;
      end
      OPC_STORE: begin
        ctl.use_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.alu_op    = ALU_SUB;
        ctl.is_branch = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  parameter int NRD   = 2
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr [NRD],
  output logic [W-1:0]             rdata [NRD]
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (raddr[g] == AW'(0)) ? '0 : regs[raddr[g]];
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import core_pkg::*;
#(
  parameter int XW    = XLEN,
  parameter int NREGS = 32
) (
  input  logic          clk,
  input  logic          rst,
  output logic [XW-1:0] imem_addr,
  input  logic [XW-1:0] imem_rdata,
  output logic [XW-1:0] dmem_addr,
  output logic [XW-1:0] dmem_wdata,
  input  logic [XW-1:0] dmem_rdata,
  output logic          dmem_we,
  output logic          dmem_re
);
  localparam int IMMW = 16;

  logic [XW-1:0]   pc, pc_plus4, br_target, pc_next, sext;
  logic [RIDX-1:0] f_rs, f_rt, f_rd, wreg;
  logic [RIDX-1:0] raddr [2];
  logic [XW-1:0]   rdata [2];
  logic [XW-1:0]   rs_val, rt_val, alu_b, alu_y, wb_data;
  logic            alu_zero, take;
  ctrl_t           ctl;

  assign f_rs = imem_rdata[25:21];
  assign f_rt = imem_rdata[20:16];
  assign f_rd = imem_rdata[15:11];
  assign sext = {{(XW-IMMW){imem_rdata[IMMW-1]}}, imem_rdata[IMMW-1:0]};

  core_ctrl u_ctrl (
    .opcode (imem_rdata[31:26]),
    .shamt  (imem_rdata[10:6]),
    .funct  (imem_rdata[5:0]),
    .ctl    (ctl)
  );

  assign raddr[0] = f_rs;
  assign raddr[1] = f_rt;
  assign wreg     = ctl.dst_is_rd ? f_rd : f_rt;

  core_regfile #(.W(XW), .DEPTH(NREGS), .NRD(2)) u_rf (
    .clk   (clk),
    .we    (ctl.reg_we),
    .waddr (wreg),
    .wdata (wb_data),
    .raddr (raddr),
    .rdata (rdata)
  );

  assign rs_val = rdata[0];
  assign rt_val = rdata[1];
  assign alu_b  = ctl.use_imm ? sext : rt_val;

  core_alu #(.W(XW)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (ctl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign wb_data = ctl.wb_from_mem ? dmem_rdata : alu_y;

  assign pc_plus4  = pc + XW'(4);
  assign br_target = pc_plus4 + (sext << 2);
  assign take      = ctl.is_branch & alu_zero;
  assign pc_next   = take ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl.mem_we;
  assign dmem_re    = ctl.mem_re;

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    !take |=> imem_addr == $past(imem_addr) + XW'(4));

  assert_branch_eq_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl.is_branch && take) |-> rs_val == rt_val);

  assert_branch_ne_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl.is_branch && !take) |-> rs_val != rt_val);

  assert_store_no_wb_R6: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !ctl.reg_we);

  assert_mem_strobes_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dmem_we, dmem_re}));
endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sc_core u_dut (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .dmem_we(dmem_we), .dmem_re(dmem_re)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  localparam int NPROG = 25;
  localparam logic [31:0] PROG [NPROG] = '{
    {6'h23, 5'd0, 5'd1, 16'd0},                 // 0  lw r1,0(r0)
    {6'h23, 5'd0, 5'd2, 16'd4},                 // 1  lw r2,4(r0)
    {6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20},     // 2  add r3=r1+r2
    {6'h00, 5'd1, 5'd2, 5'd4, 5'd0, 6'h22},     // 3  sub r4=r1-r2
    {6'h00, 5'd1, 5'd2, 5'd5, 5'd0, 6'h24},     // 4  and r5
    {6'h00, 5'd1, 5'd2, 5'd6, 5'd0, 6'h25},     // 5  or  r6
    {6'h00, 5'd4, 5'd1, 5'd7, 5'd0, 6'h2A},     // 6  slt r7=(r4<r1)
    {6'h00, 5'd1, 5'd4, 5'd8, 5'd0, 6'h2A},     // 7  slt r8=(r1<r4)
    {6'h00, 5'd1, 5'd2, 5'd0, 5'd0, 6'h20},     // 8  add r0 (discarded)
    {6'h2B, 5'd0, 5'd3, 16'd32},                // 9  sw r3
    {6'h2B, 5'd0, 5'd4, 16'd36},                // 10 sw r4
    {6'h2B, 5'd0, 5'd5, 16'd40},                // 11 sw r5
    {6'h2B, 5'd0, 5'd6, 16'd44},                // 12 sw r6
    {6'h2B, 5'd0, 5'd7, 16'd48},                // 13 sw r7
    {6'h2B, 5'd0, 5'd8, 16'd52},                // 14 sw r8
    {6'h2B, 5'd0, 5'd0, 16'd56},                // 15 sw r0
    {6'h00, 5'd1, 5'd2, 5'd1, 5'd0, 6'h20},     // 16 add r1=r1+r2
    {6'h2B, 5'd0, 5'd1, 16'd60},                // 17 sw r1
    {6'h04, 5'd1, 5'd2, 16'd5},                 // 18 beq r1,r2 (not taken)
    {6'h04, 5'd3, 5'd1, 16'd2},                 // 19 beq r3,r1 (taken -> 88)
    {6'h2B, 5'd0, 5'd1, 16'd64},                // 20 skipped
    {6'h2B, 5'd0, 5'd1, 16'd64},                // 21 skipped
    {6'h23, 5'd3, 5'd9, 16'hFFFC},              // 22 lw r9,-4(r3)
    {6'h2B, 5'd0, 5'd9, 16'd68},                // 23 sw r9
    {6'h04, 5'd0, 5'd0, 16'hFFFF}               // 24 beq r0,r0,-1 (self)
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pc(input int k);
    if (k < 20)       return 32'(4 * k);
    else if (k == 20) return 32'd88;
    else if (k == 21) return 32'd92;
    else              return 32'd96;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'hFC00_0000;
      dmem[i] = 32'hDEAD_BEEF;
    end
    for (int i = 0; i < NPROG; i++) imem[i] = PROG[i];
    dmem[0] = 32'd5;
    dmem[1] = 32'd7;
    dmem[2] = 32'h1234_5678;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", imem_addr, 32'd0);
    rst = 1'b0;
    for (int k = 1; k < 24; k++) begin
      @(negedge clk);
      chk((k == 20) ? "R3 taken branch" : "R2 pc step", imem_addr, exp_pc(k));
    end

    chk("R4 add",        dmem[8],  32'd12);
    chk("R4 sub",        dmem[9],  32'hFFFF_FFFE);
    chk("R4 and",        dmem[10], 32'd5);
    chk("R4 or",         dmem[11], 32'd7);
    chk("R4 slt signed true",  dmem[12], 32'd1);
    chk("R4 slt signed false", dmem[13], 32'd0);
    chk("R7 r0 stays zero",    dmem[14], 32'd0);
    chk("R8 read before write", dmem[15], 32'd12);
    chk("R3 skipped store",    dmem[16], 32'hDEAD_BEEF);
    chk("R5 load negative offset", dmem[17], 32'h1234_5678);
    chk("R6 no stray store",   dmem[18], 32'hDEAD_BEEF);
    chk("R5 load source kept", dmem[0],  32'd5);

    // R9 directed: r1 holds 12; a shamt!=0 add and an unknown opcode must not disturb it
    rst = 1'b1;
    imem[0] = {6'h00, 5'd2, 5'd2, 5'd1, 5'd3, 6'h20};
    imem[1] = {6'h3F, 5'd0, 5'd1, 16'd0};
    imem[2] = {6'h2B, 5'd0, 5'd1, 16'd72};
    imem[3] = {6'h04, 5'd0, 5'd0, 16'hFFFF};
    @(posedge clk);
    @(negedge clk);
    chk("R1 re-reset pc", imem_addr, 32'd0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 ignored words", dmem[18], 32'd12);
    chk("R3 self loop", imem_addr, 32'd12);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule